// File: doc/BRIEF.md
# Split Transaction Completer Queue

This block sits in a bus completer that cannot answer a read right away. It does not make the requester retry. It takes the read into a small table of pending entries and answers with a split response, which lets the requester end its cycle and leave the bus free. The table keeps the address, the transaction type, the byte count and the requester identity. When the backend reports that an entry's data is ready, the block asks for the bus. Once it is granted, it drives a completion cycle that carries the stored header and the data words back toward the requester. That cycle acts like a write aimed at the requester.

A read therefore uses two bus transactions, the request and the completion, and other traffic can run in between. The size of the completion is fixed when the request arrives, from its byte count. When every table entry is in use, a new read gets a retry response, the same as a completer without split support would give. The backend does not push data. It returns the word selected by a tag and word index that the block drives during the completion.

Top module: `split_cpl_queue`

## Requirements
- R1: A request arriving with at least one free entry gets `rsp_split` in the same cycle. `rsp_tag` names the lowest-numbered free entry, and that entry holds the request from the next cycle on.
- R2: A request arriving while all DEPTH entries are in use gets `rsp_retry` and not `rsp_split`, and it is not recorded. No completion is ever produced for it.
- R3: Every beat of a completion carries the address, type code, byte count and requester ID that were stored with the entry, unchanged across the beats.
- R4: `bus_req` is high exactly when at least one ready entry is waiting and no completion is in progress. A grant that arrives while `bus_req` is low is ignored. A grant that arrives while `bus_req` is high starts the completion in the next cycle.
- R5: A completion lasts ceil(bytes/4) beats, with a byte count of 0 giving one beat. `cpl_last` is high only on the final beat.
- R6: Completions are issued in the order in which the backend marked entries ready, whatever order the requests arrived in.
- R7: An entry is released at the clock edge that ends its last beat. A request in the following cycle can be given that entry.
- R8: A backend ready strobe is ignored when it names an entry that is free or has already been marked ready. It does not cause an extra completion.
- R9: After reset the table is empty, and `bus_req`, `cpl_valid`, `rsp_split` and `rsp_retry` are low.
- R10: During beat k of a completion for entry t, `bk_rd_tag` equals t and `bk_rd_idx` equals k. `cpl_data` passes `bk_rdata` through in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A read request is present this cycle |
| req_addr | input | AW | Request address |
| req_kind | input | KW | Transaction type code |
| req_bytes | input | BCW | Byte count |
| req_id | input | IDW | Requester identity |
| rsp_split | output | 1 | Request accepted and deferred |
| rsp_retry | output | 1 | Table full, requester must retry |
| rsp_tag | output | TW | Entry assigned on a split |
| bk_ready | input | 1 | Backend strobe: data of an entry is available |
| bk_tag | input | TW | Entry named by the ready strobe |
| bk_rd_tag | output | TW | Entry whose data word is wanted |
| bk_rd_idx | output | BCW | Word index wanted |
| bk_rdata | input | DW | Data word for the selected entry and index |
| bus_req | output | 1 | Bus request for a completion |
| bus_gnt | input | 1 | Bus grant |
| cpl_valid | output | 1 | Completion beat on the bus |
| cpl_last | output | 1 | Final beat of the completion |
| cpl_id | output | IDW | Requester identity being answered |
| cpl_addr | output | AW | Original request address |
| cpl_kind | output | KW | Original type code |
| cpl_bytes | output | BCW | Original byte count |
| cpl_data | output | DW | Completion data word |

## Verification
The bench fills the table with mixed byte counts and then checks that a further read is retried. A design with an off-by-one full test would split it into an entry that is already in use. It marks entries ready in an order different from arrival, so a design that answers oldest-first would return the wrong requester ID. It sends a repeated ready strobe and one for a freed entry, which a careless design would turn into a phantom completion, and it sends a grant while nothing is waiting, which must start nothing. Byte counts of 0, 1, 5, 8 and 13 test the rounding of the beat count, where a wrong count shows up as a misplaced last beat. Reusing an entry right after its completion shows whether the entry is released too late or too early.

// File: rtl/split_cpl_queue.sv
module split_cpl_queue #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int IDW   = 8,
  parameter int BCW   = 8,
  parameter int KW    = 2,
  parameter int DEPTH = 4,
  localparam int TW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic [AW-1:0]  req_addr,
  input  logic [KW-1:0]  req_kind,
  input  logic [BCW-1:0] req_bytes,
  input  logic [IDW-1:0] req_id,
  output logic           rsp_split,
  output logic           rsp_retry,
  output logic [TW-1:0]  rsp_tag,
  input  logic           bk_ready,
  input  logic [TW-1:0]  bk_tag,
  output logic [TW-1:0]  bk_rd_tag,
  output logic [BCW-1:0] bk_rd_idx,
  input  logic [DW-1:0]  bk_rdata,
  output logic           bus_req,
  input  logic           bus_gnt,
  output logic           cpl_valid,
  output logic           cpl_last,
  output logic [IDW-1:0] cpl_id,
  output logic [AW-1:0]  cpl_addr,
  output logic [KW-1:0]  cpl_kind,
  output logic [BCW-1:0] cpl_bytes,
  output logic [DW-1:0]  cpl_data
);

  logic [DEPTH-1:0] vld, rdy;
  logic [AW-1:0]    e_addr  [DEPTH];
  logic [KW-1:0]    e_kind  [DEPTH];
  logic [BCW-1:0]   e_bytes [DEPTH];
  logic [IDW-1:0]   e_id    [DEPTH];

  logic [TW-1:0] rq [DEPTH];
  logic [TW-1:0] rq_wp, rq_rp;
  logic [CW-1:0] rq_cnt;

  logic          busy;
  logic [TW-1:0] cur;
  logic [BCW-1:0] beat;
  logic [TW-1:0] free_tag;

  function automatic logic [TW-1:0] nxt(input logic [TW-1:0] p);
    return (p == TW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    free_tag = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!vld[i]) free_tag = TW'(i);
  end

  wire full  = &vld;
  wire push  = bk_ready && vld[bk_tag] && !rdy[bk_tag];
  wire start = bus_req && bus_gnt;

  wire [BCW:0] sum   = {1'b0, e_bytes[cur]} + (BCW+1)'(3);
  wire [BCW:0] words = (e_bytes[cur] == '0) ? (BCW+1)'(1) : (sum >> 2);
  wire         lastw = ({1'b0, beat} == words - 1'b1);

  assign rsp_split = req_valid && !full;
  assign rsp_retry = req_valid && full;
  assign rsp_tag   = free_tag;
  assign bus_req   = !busy && (rq_cnt != '0);

  assign cpl_valid = busy;
  assign cpl_last  = busy && lastw;
  assign cpl_id    = e_id[cur];
  assign cpl_addr  = e_addr[cur];
  assign cpl_kind  = e_kind[cur];
  assign cpl_bytes = e_bytes[cur];
  assign cpl_data  = bk_rdata;
  assign bk_rd_tag = cur;
  assign bk_rd_idx = beat;

  always_ff @(posedge clk) begin
    if (rsp_split) begin
      e_addr[free_tag]  <= req_addr;
      e_kind[free_tag]  <= req_kind;
      e_bytes[free_tag] <= req_bytes;
      e_id[free_tag]    <= req_id;
    end
    if (push) rq[rq_wp] <= bk_tag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld    <= '0;
      rdy    <= '0;
      rq_wp  <= '0;
      rq_rp  <= '0;
      rq_cnt <= '0;
      busy   <= 1'b0;
      cur    <= '0;
      beat   <= '0;
    end else begin
      if (rsp_split) vld[free_tag] <= 1'b1;
      if (push) begin
        rdy[bk_tag] <= 1'b1;
        rq_wp       <= nxt(rq_wp);
      end
      if (start) begin
        busy  <= 1'b1;
        cur   <= rq[rq_rp];
        beat  <= '0;
        rq_rp <= nxt(rq_rp);
      end
      case ({push, start})
        2'b10:   rq_cnt <= rq_cnt + 1'b1;
        2'b01:   rq_cnt <= rq_cnt - 1'b1;
        default: rq_cnt <= rq_cnt;
      endcase
      if (busy) begin
        beat <= beat + 1'b1;
        if (lastw) begin
          busy     <= 1'b0;
          vld[cur] <= 1'b0;
          rdy[cur] <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/split_cpl_queue_chk.sv
module split_cpl_queue_chk #(
  parameter int AW    = 32,
  parameter int IDW   = 8,
  parameter int BCW   = 8,
  parameter int DEPTH = 4,
  localparam int TW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rsp_split,
  input logic             rsp_retry,
  input logic [TW-1:0]    rsp_tag,
  input logic             bus_req,
  input logic             bus_gnt,
  input logic             cpl_valid,
  input logic             cpl_last,
  input logic [IDW-1:0]   cpl_id,
  input logic [AW-1:0]    cpl_addr,
  input logic [BCW-1:0]   bk_rd_idx,
  input logic [DEPTH-1:0] vld,
  input logic [TW-1:0]    cur
);

  p_one_answer_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_split && rsp_retry));

  p_split_recorded_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_split |=> vld[$past(rsp_tag)]);

  p_req_not_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !cpl_valid);

  p_gnt_starts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt) |=> cpl_valid);

  p_hdr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && !cpl_last) |=> (cpl_valid && $stable(cpl_id) && $stable(cpl_addr)));

  p_idx_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && !cpl_last) |=> (bk_rd_idx == $past(bk_rd_idx) + 1'b1));

  p_last_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && cpl_last) |=> !vld[$past(cur)]);

endmodule

bind split_cpl_queue split_cpl_queue_chk #(
  .AW(AW), .IDW(IDW), .BCW(BCW), .DEPTH(DEPTH)
) chk (
  .clk(clk), .rst_n(rst_n), .rsp_split(rsp_split), .rsp_retry(rsp_retry),
  .rsp_tag(rsp_tag), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .cpl_valid(cpl_valid), .cpl_last(cpl_last), .cpl_id(cpl_id),
  .cpl_addr(cpl_addr), .bk_rd_idx(bk_rd_idx), .vld(vld), .cur(cur)
);

// File: tb/split_cpl_queue_test.sv
module split_cpl_queue_test;
  localparam int TW = 2;

  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0;
  logic [31:0] req_addr = 0;
  logic [1:0]  req_kind = 0;
  logic [7:0]  req_bytes = 0, req_id = 0;
  logic        rsp_split, rsp_retry;
  logic [1:0]  rsp_tag;
  logic        bk_ready = 0;
  logic [1:0]  bk_tag = 0;
  logic [1:0]  bk_rd_tag;
  logic [7:0]  bk_rd_idx;
  logic [31:0] bk_rdata;
  logic        bus_req, bus_gnt = 0;
  logic        cpl_valid, cpl_last;
  logic [7:0]  cpl_id, cpl_bytes;
  logic [31:0] cpl_addr, cpl_data;
  logic [1:0]  cpl_kind;

  always #10 clk = ~clk;

  assign bk_rdata = {8'hC0, 6'd0, bk_rd_tag, 8'h5A, bk_rd_idx};

  split_cpl_queue uut (.*);

  int nvec = 0, nbad = 0;
  bit done = 0;

  // id, bytes, kind, addr, expect split, expect tag
  localparam int NV = 5;
  localparam logic [52:0] VEC [NV] = '{
    {8'd11, 8'd8,  2'd1, 32'h1000_0040, 1'b1, 2'd0},
    {8'd22, 8'd1,  2'd2, 32'h2000_0004, 1'b1, 2'd1},
    {8'd33, 8'd13, 2'd3, 32'h3000_0100, 1'b1, 2'd2},
    {8'd44, 8'd0,  2'd0, 32'h4000_0010, 1'b1, 2'd3},
    {8'd99, 8'd4,  2'd1, 32'h9000_0000, 1'b0, 2'd0}
  };

  logic [7:0]  t_id [4], t_bytes [4];
  logic [31:0] t_addr [4];
  logic [1:0]  t_kind [4];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_req(input logic [7:0] id, input logic [7:0] bytes, input logic [1:0] kind,
                          input logic [31:0] addr, input bit exp_split, input logic [1:0] exp_tag,
                          input string req);
    req_valid = 1; req_id = id; req_bytes = bytes; req_kind = kind; req_addr = addr;
    #1;
    chk(rsp_split == exp_split, req, 64'(rsp_split), 64'(exp_split));
    chk(rsp_retry == !exp_split, req, 64'(rsp_retry), 64'(!exp_split));
    if (exp_split) begin
      chk(rsp_tag == exp_tag, req, 64'(rsp_tag), 64'(exp_tag));
      t_id[exp_tag] = id; t_bytes[exp_tag] = bytes; t_kind[exp_tag] = kind; t_addr[exp_tag] = addr;
    end
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic mark_ready(input logic [1:0] tag);
    bk_ready = 1; bk_tag = tag;
    @(negedge clk);
    bk_ready = 0;
  endtask

  task automatic complete(input logic [1:0] tag);
    int words;
    words = (t_bytes[tag] == 0) ? 1 : (int'(t_bytes[tag]) + 3) / 4;
    chk(bus_req == 1, "R4 bus_req before grant", 64'(bus_req), 64'd1);
    bus_gnt = 1;
    @(negedge clk);
    bus_gnt = 0;
    for (int k = 0; k < words; k++) begin
      chk(cpl_valid == 1, "R5 beat valid", 64'(cpl_valid), 64'd1);
      chk(cpl_id == t_id[tag], "R6 completion order id", 64'(cpl_id), 64'(t_id[tag]));
      chk(cpl_addr == t_addr[tag], "R3 addr", 64'(cpl_addr), 64'(t_addr[tag]));
      chk(cpl_kind == t_kind[tag] && cpl_bytes == t_bytes[tag], "R3 kind/bytes",
          64'({cpl_kind, cpl_bytes}), 64'({t_kind[tag], t_bytes[tag]}));
      chk(cpl_data == {8'hC0, 6'd0, tag, 8'h5A, 8'(k)}, "R10 data word", 64'(cpl_data),
          64'({8'hC0, 6'd0, tag, 8'h5A, 8'(k)}));
      chk(cpl_last == (k == words - 1), "R5 last flag", 64'(cpl_last), 64'(k == words - 1));
      @(negedge clk);
    end
    chk(cpl_valid == 0, "R5 completion length", 64'(cpl_valid), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(bus_req == 0 && cpl_valid == 0 && rsp_split == 0 && rsp_retry == 0, "R9 reset outputs",
        64'({bus_req, cpl_valid, rsp_split, rsp_retry}), 64'd0);
    rst_n = 1;
    @(negedge clk);
    chk(bus_req == 0, "R9 empty after reset", 64'(bus_req), 64'd0);

    for (int i = 0; i < NV; i++)
      send_req(VEC[i][52:45], VEC[i][44:37], VEC[i][36:35], VEC[i][34:3], VEC[i][2], VEC[i][1:0],
               VEC[i][2] ? "R1 split" : "R2 retry when full");

    mark_ready(2);
    chk(bus_req == 1, "R4 request after ready", 64'(bus_req), 64'd1);
    mark_ready(0);
    mark_ready(2);
    send_req(8'd77, 8'd4, 2'd0, 32'h7, 1'b0, 2'd0, "R2 still retried");

    complete(2);
    send_req(8'd55, 8'd5, 2'd2, 32'h5500_0000, 1'b1, 2'd2, "R7 freed entry reused");
    complete(0);
    chk(bus_req == 0, "R8 duplicate ready ignored", 64'(bus_req), 64'd0);

    mark_ready(0);
    chk(bus_req == 0, "R8 ready on free entry ignored", 64'(bus_req), 64'd0);

    bus_gnt = 1;
    @(negedge clk);
    bus_gnt = 0;
    chk(cpl_valid == 0, "R4 stray grant ignored", 64'(cpl_valid), 64'd0);

    mark_ready(3);
    mark_ready(1);
    mark_ready(2);
    complete(3);
    complete(1);
    complete(2);
    chk(bus_req == 0, "R4 idle when drained", 64'(bus_req), 64'd0);
    send_req(8'd66, 8'd2, 2'd1, 32'h6, 1'b1, 2'd0, "R1 lowest free entry");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nvec++; nbad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule